// File: doc/BRIEF.md
# Clock Manager Control Register File

This block is the software-facing register set of a clock manager that looks after three PLL groups: main, peripheral and SDRAM. Boot software reaches it over a simple 32-bit register bus with separate read and write strobes. It uses the block to place PLLs in bypass, to leave safe mode, to gate each group's clocks, and to hold each PLL's VCO settings. It also loads the SDRAM output counters and reads back their phase as it moves. Loss of lock on any PLL raises a sticky interrupt.

Changes to bypass and to safe mode do not reach the clock tree at once. Each write starts a busy interval that software polls in a status word, and the new setting takes effect on the cycle the interval ends. A written phase target on an SDRAM counter is approached one step at a time, and the register reads back the phase in use at that moment. The analog PLLs, clock muxes and dividers sit outside the block: lock arrives as inputs, and bypass, safe mode and the clock gates leave as outputs.

Top module: `clkmgr_regs`

## Requirements
- R1: After reset, `byp_o` is 3'b111, `safe_o` is 1, every gate output is all ones, `irq_o` is 0, every VCO word reads 0x4 (power-down bit set, all else 0), and counter words read 0.
- R2: The bypass word is at word address 0, with bit 0 for main, bit 1 for peripheral and bit 2 for SDRAM. A write reads back at once. Status bit 0 reads 1 for exactly BUSY_CYC cycles after the write edge. `byp_o` takes the written value on the edge where that busy bit falls. Writing 0 releases all three PLLs.
- R3: The control word is at word address 1, and bit 0 is the safe-mode flag. Writing 1 to bit 0 sets status bit 1 busy for BUSY_CYC cycles, then drives `safe_o` to 0, and bit 0 reads 0 from the write onward. Writing 0 to bit 0 leaves safe mode as it is. Once left, safe mode is never re-entered before reset.
- R4: The gate words for main, peripheral and SDRAM are at word addresses 4, 5 and 6. A write drives the matching gate output from the next edge and reads back. The other groups keep their values.
- R5: The VCO words for main, peripheral and SDRAM are at word addresses 7, 8 and 9. They hold enable at bit 0, output-reset-all at bit 1, power-down at bit 2, source select at bits 4:3, numerator at bits 16:5 and denominator at bits 22:17. Bits 31:23 read 0. The VCO frequency the fields stand for is reference × (numerator + 1) / (denominator + 1).
- R6: The SDRAM counter words are at word addresses 10 to 13. Each holds a count at bits 8:0, which applies at once, and a phase at bits 20:12. A write sets a phase target. The phase moves by one toward the target every STEP_CYC cycles, upward or downward, with the first step STEP_CYC edges after the write, and a read returns the current phase.
- R7: The lost-lock word is at word address 3, with one bit for each PLL in the bit order of R2. A bit sets on the edge after that PLL's lock input goes from 1 to 0 and stays set while lock returns. `irq_o` is 1 while any bit is set.
- R8: Writing 1 to a lost-lock bit clears it, and writing 0 leaves it. When a new loss and a clear of the same bit meet on one edge, the bit stays set.
- R9: The status word is at word address 2, with bypass busy at bit 0, control busy at bit 1 and the lock inputs at bits 6:4. Writes to it are ignored. Word addresses 14 and 15 ignore writes and read 0. Read data is registered and valid one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pll_lock_i | input | 3 | Lock from main, peripheral, SDRAM PLLs |
| byp_o | output | 3 | Bypass per PLL, applied setting |
| safe_o | output | 1 | Safe mode active |
| gate_main_o | output | GATE_W | Main group clock enables |
| gate_peri_o | output | GATE_W | Peripheral group clock enables |
| gate_sdr_o | output | GATE_W | SDRAM group clock enables |
| irq_o | output | 1 | Any PLL has lost lock |

## Verification
Read data is due one edge after the strobe. Gate outputs are due one edge after the write. The bypass and safe-mode outputs change exactly BUSY_CYC edges after the write, and the busy bit is sampled on the last busy edge and on the first idle edge. Phase reads are placed STEP_CYC+1 edges after a write, to catch the first step, and again long after it, to catch the settled value. The scoreboard pairs every read with the edge its strobe was sampled on, and port checks are made at the falling clock edge, which counts each register between the stimulus and the output.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int unsigned NPLL     = 3;
  localparam int unsigned PLL_MAIN = 0;
  localparam int unsigned PLL_PERI = 1;
  localparam int unsigned PLL_SDR  = 2;

  // word addresses
  localparam int unsigned A_BYP   = 0;
  localparam int unsigned A_CTL   = 1;
  localparam int unsigned A_STAT  = 2;
  localparam int unsigned A_LOST  = 3;
  localparam int unsigned A_GATE0 = 4;
  localparam int unsigned A_VCO0  = 7;
  localparam int unsigned A_CTR0  = 10;

  localparam int unsigned STAT_LOCK_LSB = 4;

  // VCO word layout
  localparam int unsigned VCO_W        = 23;
  localparam int unsigned VCO_PDN_BIT  = 2;
  localparam logic [VCO_W-1:0] VCO_RST = VCO_W'(1 << VCO_PDN_BIT);

  // SDRAM counter word layout
  localparam int unsigned CNT_W  = 9;
  localparam int unsigned PH_LSB = 12;
  localparam int unsigned PH_W   = 9;
endpackage

// File: rtl/ccm_busy_gate.sv
module ccm_busy_gate #(
  parameter int unsigned W        = 3,
  parameter int unsigned BUSY_CYC = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] act_o,
  output logic         busy_o
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  pend_q, pend_d;
  logic [W-1:0]  act_q, act_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    act_d  = act_q;
    if (load_i) begin
      cnt_d  = CW'(BUSY_CYC);
      pend_d = val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) act_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= RST_VAL;
      act_q  <= RST_VAL;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign busy_o = (cnt_q != '0);

  AST_LOAD_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o); // R2
  AST_APPLY_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> ($past(busy_o) && !busy_o)); // R2
endmodule

// File: rtl/ccm_phase_step.sv
module ccm_phase_step #(
  parameter int unsigned PH_W     = 9,
  parameter int unsigned STEP_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PH_W-1:0] tgt_i,
  output logic [PH_W-1:0] cur_o
);
  localparam int unsigned DW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(STEP_CYC - 1);

  logic [PH_W-1:0] cur_q, cur_d, tgt_q, tgt_d;
  logic [DW-1:0]   div_q, div_d;

  always_comb begin
    cur_d = cur_q;
    tgt_d = tgt_q;
    div_d = div_q;
    if (load_i) begin
      tgt_d = tgt_i;
      div_d = '0;
    end else if (cur_q != tgt_q) begin
      if (div_q == DIV_LAST) begin
        div_d = '0;
        cur_d = (tgt_q > cur_q) ? cur_q + 1'b1 : cur_q - 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end else begin
      div_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      tgt_q <= '0;
      div_q <= '0;
    end else begin
      cur_q <= cur_d;
      tgt_q <= tgt_d;
      div_q <= div_d;
    end
  end

  assign cur_o = cur_q;

  AST_PHASE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> (((cur_q - $past(cur_q)) == PH_W'(1)) ||
                         (($past(cur_q) - cur_q) == PH_W'(1)))); // R6
  AST_PHASE_HOLDS_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_q == tgt_q) && !load_i) |=> $stable(cur_q)); // R6
endmodule

// File: rtl/ccm_lock_mon.sv
module ccm_lock_mon #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lock_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lost_o
);
  logic [N-1:0] lock_q, lost_q, lost_d, fall;

  always_comb begin
    fall   = lock_q & ~lock_i;
    lost_d = (lost_q & ~clr_i) | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      lost_q <= '0;
    end else begin
      lock_q <= lock_i;
      lost_q <= lost_d;
    end
  end

  assign lost_o = lost_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_q[g] && !clr_i[g]) |=> lost_q[g]); // R8
  end
endmodule

// File: rtl/clkmgr_regs.sv
module clkmgr_regs
  import ccm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GATE_W   = 32,
  parameter int unsigned BUSY_CYC = 8,
  parameter int unsigned STEP_CYC = 4,
  parameter int unsigned NCTR     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [2:0]        pll_lock_i,
  output logic [2:0]        byp_o,
  output logic              safe_o,
  output logic [GATE_W-1:0] gate_main_o,
  output logic [GATE_W-1:0] gate_peri_o,
  output logic [GATE_W-1:0] gate_sdr_o,
  output logic              irq_o
);
  // address decode
  logic            wr_byp, wr_ctl, wr_lost;
  logic [NPLL-1:0] wr_gate, wr_vco;
  logic [NCTR-1:0] wr_ctr;

  always_comb begin
    wr_byp  = bus_wr && (bus_addr == ADDR_W'(A_BYP));
    wr_ctl  = bus_wr && (bus_addr == ADDR_W'(A_CTL));
    wr_lost = bus_wr && (bus_addr == ADDR_W'(A_LOST));
    for (int i = 0; i < NPLL; i++) begin
      wr_gate[i] = bus_wr && (bus_addr == ADDR_W'(A_GATE0 + i));
      wr_vco[i]  = bus_wr && (bus_addr == ADDR_W'(A_VCO0 + i));
    end
    for (int i = 0; i < NCTR; i++) begin
      wr_ctr[i] = bus_wr && (bus_addr == ADDR_W'(A_CTR0 + i));
    end
  end

  // bypass and safe mode, each behind a busy interval
  logic [NPLL-1:0] byp_pend;
  logic            byp_busy, ctl_busy, safe_pend, safe_load;

  ccm_busy_gate #(.W(NPLL), .BUSY_CYC(BUSY_CYC), .RST_VAL({NPLL{1'b1}})) u_byp (
    .clk(clk), .rst_n(rst_n), .load_i(wr_byp), .val_i(bus_wdata[NPLL-1:0]),
    .pend_o(byp_pend), .act_o(byp_o), .busy_o(byp_busy));

  // a 1 in bit 0 leaves safe mode; a 0 keeps the pending state
  assign safe_load = bus_wdata[0] ? 1'b0 : safe_pend;

  ccm_busy_gate #(.W(1), .BUSY_CYC(BUSY_CYC), .RST_VAL(1'b1)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load_i(wr_ctl), .val_i(safe_load),
    .pend_o(safe_pend), .act_o(safe_o), .busy_o(ctl_busy));

  // gate and VCO words
  logic [GATE_W-1:0] gate_q [NPLL];
  logic [GATE_W-1:0] gate_d [NPLL];
  logic [VCO_W-1:0]  vco_q  [NPLL];
  logic [VCO_W-1:0]  vco_d  [NPLL];
  logic [CNT_W-1:0]  cnt_q  [NCTR];
  logic [CNT_W-1:0]  cnt_d  [NCTR];

  always_comb begin
    for (int i = 0; i < NPLL; i++) begin
      gate_d[i] = gate_q[i];
      vco_d[i]  = vco_q[i];
      if (wr_gate[i]) gate_d[i] = bus_wdata[GATE_W-1:0];
      if (wr_vco[i])  vco_d[i]  = bus_wdata[VCO_W-1:0];
    end
    for (int i = 0; i < NCTR; i++) begin
      cnt_d[i] = cnt_q[i];
      if (wr_ctr[i]) cnt_d[i] = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPLL; i++) begin
        gate_q[i] <= '1;
        vco_q[i]  <= VCO_RST;
      end
      for (int i = 0; i < NCTR; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPLL; i++) begin
        gate_q[i] <= gate_d[i];
        vco_q[i]  <= vco_d[i];
      end
      for (int i = 0; i < NCTR; i++) cnt_q[i] <= cnt_d[i];
    end
  end

  assign gate_main_o = gate_q[PLL_MAIN];
  assign gate_peri_o = gate_q[PLL_PERI];
  assign gate_sdr_o  = gate_q[PLL_SDR];

  // SDRAM counter phases
  logic [PH_W-1:0] ph_cur [NCTR];

  for (genvar g = 0; g < NCTR; g++) begin : g_ph
    ccm_phase_step #(.PH_W(PH_W), .STEP_CYC(STEP_CYC)) u_ph (
      .clk(clk), .rst_n(rst_n), .load_i(wr_ctr[g]),
      .tgt_i(bus_wdata[PH_LSB +: PH_W]), .cur_o(ph_cur[g]));
  end

  // lost-lock tracking
  logic [NPLL-1:0] lost, lost_clr;

  assign lost_clr = wr_lost ? bus_wdata[NPLL-1:0] : '0;

  ccm_lock_mon #(.N(NPLL)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_i(pll_lock_i), .clr_i(lost_clr),
    .lost_o(lost));

  assign irq_o = |lost;

  // read path
  logic [DATA_W-1:0] rd_word, rdata_q;

  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_W'(A_BYP))  rd_word[NPLL-1:0] = byp_pend;
    if (bus_addr == ADDR_W'(A_CTL))  rd_word[0] = safe_pend;
    if (bus_addr == ADDR_W'(A_STAT)) begin
      rd_word[0] = byp_busy;
      rd_word[1] = ctl_busy;
      rd_word[STAT_LOCK_LSB +: NPLL] = pll_lock_i;
    end
    if (bus_addr == ADDR_W'(A_LOST)) rd_word[NPLL-1:0] = lost;
    for (int i = 0; i < NPLL; i++) begin
      if (bus_addr == ADDR_W'(A_GATE0 + i)) rd_word[GATE_W-1:0] = gate_q[i];
      if (bus_addr == ADDR_W'(A_VCO0 + i))  rd_word[VCO_W-1:0]  = vco_q[i];
    end
    for (int i = 0; i < NCTR; i++) begin
      if (bus_addr == ADDR_W'(A_CTR0 + i)) begin
        rd_word[CNT_W-1:0]       = cnt_q[i];
        rd_word[PH_LSB +: PH_W]  = ph_cur[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;

  AST_SAFE_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !safe_o |=> !safe_o); // R3
endmodule

// File: tb/test_clkmgr_regs.sv
module test_clkmgr_regs;
  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  pll_lock = 3'b111;
  logic [2:0]  byp;
  logic        safe, irq;
  logic [31:0] g_main, g_peri, g_sdr;

  always #5 clk = ~clk;

  clkmgr_regs i_clkmgr_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_lock_i(pll_lock), .byp_o(byp), .safe_o(safe),
    .gate_main_o(g_main), .gate_peri_o(g_peri), .gate_sdr_o(g_sdr),
    .irq_o(irq));

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];
  logic rd_seen = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver tasks: start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp,
                    input logic [31:0] mask, input string tag);
    sb_item_t it;
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare registered read data one edge after the strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read data %h", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata & it.mask, it.exp & it.mask);
      end
    end
  end

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  function automatic logic [31:0] vco_word(input int en, input int orst, input int pdn,
                                          input int src, input int num, input int den);
    return 32'(en) | (32'(orst) << 1) | (32'(pdn) << 2) | (32'(src) << 3) |
           (32'(num) << 5) | (32'(den) << 17);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 byp_o", {29'd0, byp}, 32'h7);
    chk("R1 safe_o", {31'd0, safe}, 32'h1);
    chk("R1 gate_main_o", g_main, ALL);
    chk("R1 irq_o", {31'd0, irq}, 32'h0);
    rd(4'd7, 32'h4, ALL, "R1 main VCO reset");
    rd(4'd1, 32'h1, ALL, "R1 control reset");
    rd(4'd11, 32'h0, ALL, "R1 counter reset");

    // R2 bypass release with busy interval
    wr(4'd0, 32'h0);
    rd(4'd2, 32'h1, 32'h1, "R2 busy after write");
    rd(4'd0, 32'h0, ALL, "R2 bypass readback");
    idle(5);
    chk("R2 byp_o held while busy", {29'd0, byp}, 32'h7);
    rd(4'd2, 32'h1, 32'h1, "R2 busy on last cycle");
    chk("R2 byp_o applied at busy end", {29'd0, byp}, 32'h0);
    rd(4'd2, 32'h0, 32'h1, "R2 busy cleared");

    // R3 safe mode
    wr(4'd1, 32'h0);
    idle(BUSY + 2);
    chk("R3 write 0 keeps safe", {31'd0, safe}, 32'h1);
    wr(4'd1, 32'h1);
    rd(4'd1, 32'h0, 32'h1, "R3 control readback");
    rd(4'd2, 32'h2, 32'h2, "R3 control busy");
    idle(5);
    chk("R3 safe held while busy", {31'd0, safe}, 32'h1);
    idle(1);
    chk("R3 safe cleared", {31'd0, safe}, 32'h0);
    wr(4'd1, 32'h0);
    idle(BUSY + 2);
    chk("R3 no re-entry", {31'd0, safe}, 32'h0);

    // R4 gates
    wr(4'd5, 32'h0000_A5A5);
    chk("R4 gate_peri_o", g_peri, 32'h0000_A5A5);
    chk("R4 gate_main_o untouched", g_main, ALL);
    chk("R4 gate_sdr_o untouched", g_sdr, ALL);
    wr(4'd6, 32'h0);
    chk("R4 gate_sdr_o", g_sdr, 32'h0);
    rd(4'd5, 32'h0000_A5A5, ALL, "R4 gate readback");

    // R5 VCO fields
    wr(4'd9, ALL);
    rd(4'd9, 32'h007F_FFFF, ALL, "R5 VCO defined bits");
    wr(4'd7, vco_word(1, 0, 0, 2, 'h123, 5));
    rd(4'd7, vco_word(1, 0, 0, 2, 'h123, 5), ALL, "R5 VCO fields");
    rd(4'd8, 32'h4, ALL, "R5 other VCO untouched");

    // R6 counter and phase stepping
    wr(4'd11, 32'h1AB | (32'd3 << 12));
    rd(4'd11, 32'h0000_01AB, ALL, "R6 count now, phase 0");
    idle(3);
    rd(4'd11, 32'h0000_11AB, ALL, "R6 first step up");
    idle(20);
    rd(4'd11, 32'h0000_31AB, ALL, "R6 reached target");
    wr(4'd11, 32'd1 << 12);
    idle(4);
    rd(4'd11, 32'h0000_2000, ALL, "R6 first step down");
    idle(10);
    rd(4'd11, 32'h0000_1000, ALL, "R6 settled down");
    rd(4'd10, 32'h0, ALL, "R6 other counter untouched");

    // R7 lost lock
    rd(4'd3, 32'h0, ALL, "R7 no loss yet");
    pll_lock[1] = 1'b0;
    idle(1);
    chk("R7 irq_o on loss", {31'd0, irq}, 32'h1);
    pll_lock[1] = 1'b1;
    idle(3);
    rd(4'd3, 32'h2, ALL, "R7 sticky after relock");
    rd(4'd2, 32'h70, 32'h70, "R9 lock bits in status");

    // R8 write-1-to-clear
    wr(4'd3, 32'h5);
    rd(4'd3, 32'h2, ALL, "R8 zero bit keeps");
    wr(4'd3, 32'h2);
    chk("R8 irq_o cleared", {31'd0, irq}, 32'h0);
    pll_lock[2] = 1'b0;
    wr(4'd3, 32'h4);
    chk("R8 set wins over clear", {31'd0, irq}, 32'h1);
    rd(4'd3, 32'h4, ALL, "R8 set wins readback");
    pll_lock[2] = 1'b1;

    // R9 ignored writes
    wr(4'd2, ALL);
    rd(4'd2, 32'h70, ALL, "R9 status write ignored");
    wr(4'd15, ALL);
    rd(4'd15, 32'h0, ALL, "R9 unmapped reads 0");
    rd(4'd0, 32'h0, ALL, "R9 bypass untouched");
    chk("R9 gate_main_o untouched", g_main, ALL);

    idle(2);
    chk("scoreboard drained", 32'(sb_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule